// File: doc/BRIEF.md
# Programmable Read-Only Memory Control Decoder

This block models the control side of an 8192 x 8 ultraviolet-erasable programmable memory and is meant to be dropped into a testbench as a device model. It takes the active-low chip select, output gate and program strobe, the address bus, and two flags. One flag stands for the raised programming supply. The other stands for the raised voltage on address line 9. From these it decides which of eight operating states the part is in. It then either drives data onto its bus, holds the bus off, or programs the addressed byte.

Stored bytes live in an internal register file that starts fully erased (all ones). Programming is an AND with the presented byte, so a programmed zero cannot be undone. When the raised-address flag is set and the read conditions hold, the part answers with a fixed two-byte identity instead of array contents. Two error outputs report misuse of the strobe: a strobe held low for too long, and a strobe issued without the programming supply. The bus drive enable is a separate output, so the surrounding bench can check for bus contention.

Top module: `eprom_ctrl_model`

## Requirements
- R1: After power-up every location reads 0xFF, and after reset both error outputs are low.
- R2: With `vpp_hi_i` low and the identity read not selected, the state is decoded as follows. Chip select low, output gate low and strobe high give mode_o=0 (read, array data on the bus). Chip select low, output gate high and strobe high give mode_o=2 (output off).
- R3: With `vpp_hi_i` high, the state is decoded as follows. Chip select low, output gate high and strobe low give mode_o=3 (program, bus not driven). Chip select low, output gate low and strobe high give mode_o=4 (verify, array data driven). Chip select high gives mode_o=5 (inhibit). Chip select low with both output gate and strobe high gives mode_o=2.
- R4: `doe_o` is high exactly in modes 0, 4 and 6, and `dout_o` is 0 whenever `doe_o` is low.
- R5: With `vpp_hi_i` low and chip select high, mode_o=1 (standby) and the bus is off whatever the output gate does.
- R6: The identity read applies when `id_hv_i` is high, chip select and output gate are low, the strobe is high, and address bits 1-8 and 10-12 are all zero (bit 9 is ignored). It gives mode_o=6 with 0x8F when address bit 0 is 0 and 0xC2 when it is 1, whatever the supply flag.
- R7: In mode 3, `wr_stb_o` is high for exactly the one cycle in which the strobe is first seen low (the previous clock edge sampled it high). At that edge the location becomes its old value AND `din_i`.
- R8: A bit that has been programmed to 0 stays 0 when a later program presents a 1 for it.
- R9: A strobe with chip select high raises no `wr_stb_o` and leaves the array unchanged.
- R10: `pgm_dc_err_o` is high once the strobe has been sampled low at PGM_MAX_LOW (default 16) consecutive clock edges. It stays high until an edge samples the strobe high.
- R11: `proto_err_o` is high for the one cycle after an edge at which a falling strobe was sampled with `vpp_hi_i` low.
- R12: Any other input combination gives mode_o=7 (illegal) with the bus off. This covers output gate and strobe both low with chip select low, a strobe low with output gate high and no supply flag, and an identity request whose other address bits are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 13 | Byte address |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output gate, active low |
| pgm_ni | input | 1 | Program strobe, active low |
| vpp_hi_i | input | 1 | Programming supply raised |
| id_hv_i | input | 1 | Raised voltage on address line 9 |
| din_i | input | 8 | Byte presented for programming |
| dout_o | output | 8 | Byte driven onto the bus |
| doe_o | output | 1 | Bus drive enable |
| mode_o | output | 3 | Decoded state code |
| wr_stb_o | output | 1 | Array write strobe |
| pgm_dc_err_o | output | 1 | Strobe held low too long |
| proto_err_o | output | 1 | Strobe without programming supply |

## Verification
Two things can land in the same cycle: a falling strobe that writes the array, and a falling strobe that flags a protocol error. Because the program mode needs the supply flag, the two must never fire together. The random phase toggles the strobe and the supply flag independently, so both kinds of edge occur many times. Each cycle, a bench model predicts the strobe, the error pulse and the next read-back value, and the design's outputs are judged against that prediction. Directed cases provoke the bit-clearing rewrite, the inhibit, the identity bytes, the exact cycle in which the held-low error first rises, and the single-cycle protocol pulse.

// File: rtl/eprom_pkg.sv
`timescale 1ns/1ps
package eprom_pkg;
  typedef enum logic [2:0] {
    MD_READ = 3'd0,
    MD_STBY = 3'd1,
    MD_ODIS = 3'd2,
    MD_PROG = 3'd3,
    MD_VRFY = 3'd4,
    MD_INHB = 3'd5,
    MD_IDRD = 3'd6,
    MD_BAD  = 3'd7
  } mode_e;

  localparam logic [7:0] MFR_ID = 8'h8F;
  localparam logic [7:0] DEV_ID = 8'hC2;
  localparam int unsigned HV_BIT = 9;
endpackage

// File: rtl/eprom_mode_dec.sv
`timescale 1ns/1ps
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  output mode_e             mode_o,
  output logic              drive_o
);
  logic id_addr_ok;

  // all address bits except bit 0 and the high-voltage bit must be zero
  always_comb begin
    id_addr_ok = 1'b1;
    for (int i = 1; i < int'(ADDR_W); i++) begin
      if (i != int'(HV_BIT)) id_addr_ok = id_addr_ok & ~addr_i[i];
    end
  end

  always_comb begin
    mode_o = MD_BAD;
    if (id_hv_i && !ce_ni && !oe_ni && pgm_ni) begin
      mode_o = id_addr_ok ? MD_IDRD : MD_BAD;
    end else if (ce_ni) begin
      mode_o = vpp_hi_i ? MD_INHB : MD_STBY;
    end else if (!oe_ni) begin
      if (pgm_ni) mode_o = vpp_hi_i ? MD_VRFY : MD_READ;
      else        mode_o = MD_BAD;
    end else begin
      if (pgm_ni)        mode_o = MD_ODIS;
      else if (vpp_hi_i) mode_o = MD_PROG;
      else               mode_o = MD_BAD;
    end
  end

  assign drive_o = (mode_o == MD_READ) || (mode_o == MD_VRFY) || (mode_o == MD_IDRD);
endmodule

// File: rtl/eprom_pgm_mon.sv
`timescale 1ns/1ps
module eprom_pgm_mon #(
  parameter int unsigned PGM_MAX_LOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pgm_ni,
  input  logic vpp_hi_i,
  output logic fall_o,
  output logic dc_err_o,
  output logic proto_err_o
);
  localparam int unsigned CW = $clog2(PGM_MAX_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(PGM_MAX_LOW);

  logic          pgm_q;
  logic [CW-1:0] low_cnt;

  assign fall_o   = pgm_q & ~pgm_ni;
  assign dc_err_o = (low_cnt == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_q       <= 1'b1;
      low_cnt     <= '0;
      proto_err_o <= 1'b0;
    end else begin
      pgm_q       <= pgm_ni;
      proto_err_o <= fall_o & ~vpp_hi_i;
      if (pgm_ni)              low_cnt <= '0;
      else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eprom_cell_array.sv
`timescale 1ns/1ps
module eprom_cell_array #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // erased state: all ones; reset does not erase
  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = '1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= mem[addr_i] & wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/eprom_ctrl_model.sv
`timescale 1ns/1ps
module eprom_ctrl_model
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PGM_MAX_LOW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              doe_o,
  output logic [2:0]        mode_o,
  output logic              wr_stb_o,
  output logic              pgm_dc_err_o,
  output logic              proto_err_o
);
  mode_e             mode;
  logic              drive;
  logic              pgm_fall;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] id_byte;

  eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_i),
    .ce_ni   (ce_ni),
    .oe_ni   (oe_ni),
    .pgm_ni  (pgm_ni),
    .vpp_hi_i(vpp_hi_i),
    .id_hv_i (id_hv_i),
    .mode_o  (mode),
    .drive_o (drive)
  );

  eprom_pgm_mon #(.PGM_MAX_LOW(PGM_MAX_LOW)) u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pgm_ni     (pgm_ni),
    .vpp_hi_i   (vpp_hi_i),
    .fall_o     (pgm_fall),
    .dc_err_o   (pgm_dc_err_o),
    .proto_err_o(proto_err_o)
  );

  assign wr_stb_o = pgm_fall && (mode == MD_PROG);

  eprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk_i  (clk_i),
    .we_i   (wr_stb_o),
    .addr_i (addr_i),
    .wdata_i(din_i),
    .rdata_o(rd_data)
  );

  assign id_byte = addr_i[0] ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
  assign mode_o  = mode;
  assign doe_o   = drive;
  assign dout_o  = !drive ? '0 : (mode == MD_IDRD) ? id_byte : rd_data;
endmodule

// File: rtl/eprom_ctrl_chk.sv
`timescale 1ns/1ps
module eprom_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              pgm_ni,
  input logic              vpp_hi_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              doe_o,
  input logic [2:0]        mode_o,
  input logic              wr_stb_o,
  input logic              pgm_dc_err_o,
  input logic              proto_err_o
);
  AST_STBY_BUS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !doe_o); // R5
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !doe_o |-> (dout_o == '0)); // R4
  AST_PROG_BUS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |-> !doe_o); // R3
  AST_ID_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd6) |-> (dout_o == DATA_W'(8'h8F) || dout_o == DATA_W'(8'hC2))); // R6
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R7
  AST_STB_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (vpp_hi_i && !ce_ni)); // R9
  AST_DC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_dc_err_o |-> $past(!pgm_ni)); // R10
  AST_PROTO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(!vpp_hi_i && !pgm_ni)); // R11
  AST_BAD_BUS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd7) |-> !doe_o); // R12
endmodule

bind eprom_ctrl_model eprom_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .pgm_ni      (pgm_ni),
  .vpp_hi_i    (vpp_hi_i),
  .dout_o      (dout_o),
  .doe_o       (doe_o),
  .mode_o      (mode_o),
  .wr_stb_o    (wr_stb_o),
  .pgm_dc_err_o(pgm_dc_err_o),
  .proto_err_o (proto_err_o)
);

// File: tb/eprom_ctrl_model_tb.sv
`timescale 1ns/1ps
module eprom_ctrl_model_tb;
  localparam int AW   = 13;
  localparam int DW   = 8;
  localparam int MAXL = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, oe_n, pgm_n, vpp, idf;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          doe, wr_stb, dc_err, proto_err;
  logic [2:0]    mode;

  eprom_ctrl_model #(.ADDR_W(AW), .DATA_W(DW), .PGM_MAX_LOW(MAXL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .oe_ni(oe_n),
    .pgm_ni(pgm_n), .vpp_hi_i(vpp), .id_hv_i(idf), .din_i(din),
    .dout_o(dout), .doe_o(doe), .mode_o(mode), .wr_stb_o(wr_stb),
    .pgm_dc_err_o(dc_err), .proto_err_o(proto_err)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic prev_pgm;
  int   low_cnt;
  logic exp_proto;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mode(input logic ce, input logic oe, input logic pg,
                                          input logic vp, input logic id, input logic [AW-1:0] a);
    if (id && !ce && !oe && pg) return ((a & 13'h1DFE) == 0) ? 3'd6 : 3'd7;
    if (ce) return vp ? 3'd5 : 3'd1;
    if (!oe) return pg ? (vp ? 3'd4 : 3'd0) : 3'd7;
    if (pg) return 3'd2;
    return vp ? 3'd3 : 3'd7;
  endfunction

  task automatic step(input logic ce, input logic oe, input logic pg, input logic vp,
                      input logic id, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [2:0]    m;
    logic          drv, stb;
    logic [DW-1:0] ed;
    string         tag;
    @(negedge clk);
    ce_n = ce; oe_n = oe; pgm_n = pg; vpp = vp; idf = id; addr = a; din = d;
    #1;
    m   = exp_mode(ce, oe, pg, vp, id, a);
    drv = (m == 3'd0) || (m == 3'd4) || (m == 3'd6);
    ed  = !drv ? 8'h00 : (m == 3'd6) ? (a[0] ? 8'hC2 : 8'h8F) : ref_mem[a];
    stb = prev_pgm && !pg && (m == 3'd3);
    case (m)
      3'd1:                tag = "R5";
      3'd3, 3'd4, 3'd5:    tag = "R3";
      3'd6:                tag = "R6";
      3'd7:                tag = "R12";
      default:             tag = "R2";
    endcase
    check(tag,   "mode",  mode, m);
    check("R4",  "doe",   doe, drv);
    check(tag,   "dout",  dout, ed);
    check("R7",  "stb",   wr_stb, stb);
    check("R10", "dc",    dc_err, low_cnt >= MAXL);
    check("R11", "proto", proto_err, exp_proto);
    if (stb) ref_mem[a] = ref_mem[a] & d;
    exp_proto = prev_pgm && !pg && !vp;
    low_cnt   = pg ? 0 : (low_cnt < MAXL ? low_cnt + 1 : low_cnt);
    prev_pgm  = pg;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 8'hFF;
    prev_pgm = 1'b1; low_cnt = 0; exp_proto = 1'b0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp = 1'b0; idf = 1'b0;
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: erased read and quiet error flags
    step(0, 0, 1, 0, 0, 13'd0, 8'h00);
    check("R1", "erased", dout, 8'hFF);
    check("R1", "dc_rst", dc_err, 0);
    check("R1", "proto_rst", proto_err, 0);
    step(0, 1, 1, 0, 0, 13'd0, 8'h00);
    check("R2", "odis_mode", mode, 2);
    // R5: standby ignores output gate
    step(1, 0, 1, 0, 0, 13'd5, 8'h00);
    check("R5", "stby_doe", doe, 0);

    // R7: program A5 at 5, then verify
    step(0, 1, 1, 1, 0, 13'd5, 8'hA5);
    step(0, 1, 0, 1, 0, 13'd5, 8'hA5);
    check("R7", "stb_hi", wr_stb, 1);
    step(0, 1, 1, 1, 0, 13'd5, 8'hA5);
    step(0, 0, 1, 1, 0, 13'd5, 8'h00);
    check("R7", "verify", dout, 8'hA5);
    // R8: rewrite cannot restore ones
    step(0, 1, 0, 1, 0, 13'd5, 8'h5A);
    step(0, 1, 1, 1, 0, 13'd5, 8'h5A);
    step(0, 0, 1, 0, 0, 13'd5, 8'h00);
    check("R8", "and_only", dout, 8'h00);

    // R9: inhibited strobe
    step(1, 1, 0, 1, 0, 13'd6, 8'h00);
    check("R9", "inhb_stb", wr_stb, 0);
    step(1, 1, 1, 1, 0, 13'd6, 8'h00);
    step(0, 0, 1, 0, 0, 13'd6, 8'h00);
    check("R9", "inhb_keep", dout, 8'hFF);

    // R6 / R12: identity bytes
    step(0, 0, 1, 0, 1, 13'h0000, 8'h00);
    check("R6", "mfr", dout, 8'h8F);
    step(0, 0, 1, 1, 1, 13'h0001, 8'h00);
    check("R6", "dev", dout, 8'hC2);
    step(0, 0, 1, 0, 1, 13'h0201, 8'h00);
    check("R6", "bit9_dc", dout, 8'hC2);
    step(0, 0, 1, 0, 1, 13'h0003, 8'h00);
    check("R12", "id_bad_addr", mode, 7);
    step(0, 0, 0, 1, 0, 13'd0, 8'h00);
    check("R12", "both_low", doe, 0);
    step(0, 1, 1, 1, 0, 13'd0, 8'h00);

    // R10: strobe held low
    for (int k = 0; k < MAXL; k++) step(1, 1, 0, 1, 0, 13'd7, 8'h00);
    check("R10", "dc_edge_minus1", dc_err, 0);
    step(1, 1, 0, 1, 0, 13'd7, 8'h00);
    check("R10", "dc_set", dc_err, 1);
    step(1, 1, 1, 1, 0, 13'd7, 8'h00);
    step(1, 1, 1, 1, 0, 13'd7, 8'h00);
    check("R10", "dc_clear", dc_err, 0);

    // R11: strobe without supply
    step(0, 0, 1, 0, 0, 13'd0, 8'h00);
    step(0, 0, 0, 0, 0, 13'd0, 8'h00);
    step(0, 0, 1, 0, 0, 13'd0, 8'h00);
    check("R11", "proto_pulse", proto_err, 1);
    step(0, 0, 1, 0, 0, 13'd0, 8'h00);
    check("R11", "proto_one", proto_err, 0);

    // mixed random traffic checked against the bench model
    for (int n = 0; n < 4000; n++) begin
      logic          rc, ro, rp, rv, ri;
      logic [AW-1:0] ra;
      rc = ($urandom % 4) == 0;
      ro = $urandom % 2;
      rp = ($urandom % 3) != 0;
      rv = $urandom % 2;
      ri = ($urandom % 8) == 0;
      if (($urandom % 4) == 0) ra = AW'($urandom % (1 << AW));
      else if ($urandom % 2)   ra = AW'($urandom % 2);
      else                     ra = AW'($urandom % 8);
      step(rc, ro, rp, rv, ri, ra, 8'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule